// File: doc/BRIEF.md
# Power-down and lock-wait controller

This block sits between the control pins of a spread-spectrum clock generator and its analog core. An active-high enable pin selects between running and sleeping. When it goes low, the oscillator and PLL are asked to shut down at once and the clock pad driver is released. All internal copies of the configuration inputs are forced to zero at the same moment. The configuration inputs are a multiply select, a spread-type select and a two-bit modulation-depth code.

A settled clock is not promised right after the generator wakes, or after its configuration is altered. A reloadable down-counter, paced by a free-running timebase tick, measures a lock wait. Each wake-up or configuration change starts that wait over. A clock-valid flag tells downstream logic when it may release its own resets. The configuration pins and the enable pass through synchronizer chains before they feed change detection and the timer, so a metastable sample cannot trigger a false restart. The default wait is 10,000 ticks, which is 10 ms with a 1 µs tick.

Top module: `clkseq_pwr_ctrl`

## Requirements
- R1: `pad_drive_o` follows `en_pin_i` and `core_pd_o` is its inverse. Both respond combinationally, with no clock edge between the pin and the outputs.
- R2: While `en_pin_i` is 0, `mult_o`, `spread_o` and `rate_o` are all 0, whatever levels the configuration pins carry.
- R3: While `en_pin_i` is 1, `mult_o`, `spread_o` and `rate_o` show the levels of `mult_pin_i`, `spread_pin_i` and `rate_pin_i[1:0]` from SYNC_STAGES (default 2) rising edges earlier.
- R4: When the enable rises and `tick_i` is high on every cycle, `clk_ok_o` first reads 1 after the (LOCK_TICKS+2)th rising edge, and it stays 1 until the next restart.
- R5: A change on any configuration pin while enabled drops `clk_ok_o` once the change has crossed the synchronizer, which takes 2 edges. With `tick_i` high on every cycle, `clk_ok_o` returns after the (LOCK_TICKS+3)th edge counted from the change. A second change during the wait restarts the full interval.
- R6: `clk_ok_o` goes to 0 in the same cycle that `en_pin_i` falls, with no clock edge needed.
- R7: An enable low pulse of one clock period tri-states the pad while it lasts. It also forces a full lock wait: `clk_ok_o` returns after the (LOCK_TICKS+3)th edge counted from the start of the pulse.
- R8: The lock timer advances only on cycles where `tick_i` is 1. With `tick_i` held at 0, `clk_ok_o` never asserts. Once ticks resume, it asserts after LOCK_TICKS of them.
- R9: During reset `clk_ok_o` is 0 and the configuration outputs are 0.
- R10: Configuration pin changes made while the enable is low cause no extra delay. The wake-up timing of R4 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one cycle wide, that paces the lock wait |
| en_pin_i | input | 1 | Enable pin; 0 requests power-down |
| mult_pin_i | input | 1 | Multiply-select pin |
| spread_pin_i | input | 1 | Spread-type pin (0 centre, 1 downward) |
| rate_pin_i | input | 2 | Modulation-depth code pin (00 means no modulation) |
| core_pd_o | output | 1 | Power-down request to oscillator and PLL |
| pad_drive_o | output | 1 | Clock pad drive enable; 0 means high impedance |
| mult_o | output | 1 | Internal multiply select |
| spread_o | output | 1 | Internal spread type |
| rate_o | output | 2 | Internal modulation-depth code |
| clk_ok_o | output | 1 | Clock valid flag |

## Verification
The pad-drive, power-down and clock-valid reactions to a falling enable take zero cycles. The bench drives the pin on a falling clock edge and samples one nanosecond later, before any rising edge can intervene. Configuration outputs are due two rising edges after a pin change. Clock-valid is due LOCK_TICKS+2 edges after a wake-up and LOCK_TICKS+3 edges after a configuration change or a short enable pulse. For each of these cases the bench checks the flag one edge before its due point and again at the due point. All sampling happens on falling edges, after counting exactly that many rising edges.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
   typedef struct packed {
      logic       mult;
      logic       spread;
      logic [1:0] rate;
   } cfg_t;
   localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/clkseq_cfg_track.sv
module clkseq_cfg_track
   import clkseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_pin_i,
   input  cfg_t cfg_pin_i,
   output cfg_t cfg_int_o,
   output logic change_o
);
   cfg_t cfg_sync;
   cfg_t cfg_last;

   clkseq_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cfg_pin_i),
      .q_o   (cfg_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_last <= '0;
      else        cfg_last <= cfg_sync;
   end

   assign change_o  = (cfg_sync != cfg_last);
   // configuration seen by the core is forced low straight from the pin
   assign cfg_int_o = en_pin_i ? cfg_sync : '0;
endmodule

// File: rtl/clkseq_lock_timer.sv
module clkseq_lock_timer #(
   parameter int LOCK_TICKS = 10000,
   localparam int CW = $clog2(LOCK_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          restart_i,
   output logic [CW-1:0] cnt_o,
   output logic          done_o
);
   generate
      if (LOCK_TICKS < 1) begin : g_bad_ticks
         $error("clkseq_lock_timer: LOCK_TICKS must be at least 1");
      end
   endgenerate

   localparam logic [CW-1:0] LOAD = CW'(LOCK_TICKS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= LOAD;
      else if (restart_i)               cnt_q <= LOAD;
      else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign done_o = (cnt_q == '0);

   AST_RELOAD_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> cnt_q == LOAD); // R5
   AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !restart_i) |=> $stable(cnt_q)); // R8
   AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !restart_i) |=> done_o); // R4
endmodule

// File: rtl/clkseq_pwr_ctrl.sv
module clkseq_pwr_ctrl #(
   parameter int LOCK_TICKS  = 10000,
   parameter int SYNC_STAGES = 2,
   localparam int CW = $clog2(LOCK_TICKS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       en_pin_i,
   input  logic       mult_pin_i,
   input  logic       spread_pin_i,
   input  logic [1:0] rate_pin_i,
   output logic       core_pd_o,
   output logic       pad_drive_o,
   output logic       mult_o,
   output logic       spread_o,
   output logic [1:0] rate_o,
   output logic       clk_ok_o
);
   import clkseq_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkseq_pwr_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // enable chain: every stage must read high before the wake counts
   logic [SYNC_STAGES-1:0] en_stg;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_stg <= '0;
      else        en_stg <= {en_stg[SYNC_STAGES-2:0], en_pin_i};
   end
   logic en_settled;
   assign en_settled = &en_stg;

   cfg_t cfg_pin, cfg_int;
   logic cfg_change;
   assign cfg_pin = '{mult: mult_pin_i, spread: spread_pin_i, rate: rate_pin_i};

   clkseq_cfg_track #(.SYNC_STAGES(SYNC_STAGES)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_pin_i  (en_pin_i),
      .cfg_pin_i (cfg_pin),
      .cfg_int_o (cfg_int),
      .change_o  (cfg_change)
   );

   logic [CW-1:0] tmr_cnt;
   logic          tmr_done;
   logic          restart;
   assign restart = !en_settled || cfg_change;

   clkseq_lock_timer #(.LOCK_TICKS(LOCK_TICKS)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .restart_i (restart),
      .cnt_o     (tmr_cnt),
      .done_o    (tmr_done)
   );

   assign pad_drive_o = en_pin_i;
   assign core_pd_o   = !en_pin_i;
   assign mult_o      = cfg_int.mult;
   assign spread_o    = cfg_int.spread;
   assign rate_o      = cfg_int.rate;
   assign clk_ok_o    = tmr_done && en_pin_i && en_settled && !cfg_change;

   AST_CFG_ZERO_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
      !en_pin_i |-> ({mult_o, spread_o, rate_o} == 4'b0000)); // R2
   AST_OK_DROPS_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_pin_i |-> !clk_ok_o); // R6
   AST_OK_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_ok_o) |-> $past(tmr_cnt) == CW'(1)); // R4
endmodule

// File: tb/clkseq_pwr_ctrl_test.sv
module clkseq_pwr_ctrl_test;
   localparam int LT = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic en = 1'b1;
   logic mult = 1'b0, spread = 1'b0;
   logic [1:0] rate = 2'b00;
   logic pd, drive, mult_o, spread_o, ok;
   logic [1:0] rate_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   clkseq_pwr_ctrl #(.LOCK_TICKS(LT), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_pin_i(en),
      .mult_pin_i(mult), .spread_pin_i(spread), .rate_pin_i(rate),
      .core_pd_o(pd), .pad_drive_o(drive), .mult_o(mult_o),
      .spread_o(spread_o), .rate_o(rate_o), .clk_ok_o(ok)
   );

   // {en, mult, spread, rate[1:0], exp_drive, exp_mult, exp_spread, exp_rate[1:0]}
   localparam logic [9:0] VEC [0:7] = '{
      10'b1_1_0_01_1_1_0_01,
      10'b1_0_1_10_1_0_1_10,
      10'b0_1_1_11_0_0_0_00,
      10'b1_1_1_11_1_1_1_11,
      10'b0_0_1_01_0_0_0_00,
      10'b1_0_0_00_1_0_0_00,
      10'b1_0_0_11_1_0_0_11,
      10'b0_1_0_10_0_0_0_00
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic adv(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(4 * 20000);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      adv(3);
      chk("R9 ok in reset", ok, 0);
      chk("R9 cfg in reset", {mult_o, spread_o, rate_o}, 0);
      rst_n = 1'b1;
      adv(2);

      for (int i = 0; i < 8; i++) begin
         {en, mult, spread, rate} = VEC[i][9:5];
         adv(3);
         chk("R1 drive", drive, VEC[i][4]);
         chk("R1 pd", pd, !VEC[i][4]);
         chk(VEC[i][9] ? "R3 cfg follows" : "R2 cfg forced zero",
             {mult_o, spread_o, rate_o}, VEC[i][3:0]);
      end

      en = 1'b1; {mult, spread, rate} = 4'b0000;
      adv(20);
      chk("R4 settled", ok, 1);

      // enable falls: same-cycle response, config churn while asleep, wake
      en = 1'b0;
      #1;
      chk("R6 ok drops at once", ok, 0);
      chk("R1 drive released at once", drive, 0);
      chk("R1 pd at once", pd, 1);
      adv(5);
      {mult, spread, rate} = 4'b1111;
      adv(5);
      chk("R2 cfg zero asleep", {mult_o, spread_o, rate_o}, 0);
      en = 1'b1;
      adv(LT + 1);
      chk("R10 R4 not yet", ok, 0);
      adv(1);
      chk("R10 R4 valid on time", ok, 1);
      chk("R3 cfg after wake", {mult_o, spread_o, rate_o}, 4'b1111);

      // configuration change restarts the wait
      mult = 1'b0;
      adv(1);
      chk("R5 ok before sync", ok, 1);
      chk("R3 mult not yet", mult_o, 1);
      adv(1);
      chk("R5 ok drops", ok, 0);
      chk("R3 mult after two edges", mult_o, 0);
      adv(LT);
      chk("R5 not yet", ok, 0);
      adv(1);
      chk("R5 valid on time", ok, 1);

      // second change mid-wait restarts the full interval
      spread = 1'b0;
      adv(6);
      rate = 2'b00;
      adv(LT + 2);
      chk("R5 rechange not yet", ok, 0);
      adv(1);
      chk("R5 rechange valid", ok, 1);

      // one-cycle enable pulse
      en = 1'b0;
      #1;
      chk("R7 drive off in pulse", drive, 0);
      adv(1);
      en = 1'b1;
      #1;
      chk("R7 drive back", drive, 1);
      adv(LT + 1);
      chk("R7 not yet", ok, 0);
      adv(1);
      chk("R7 valid after full wait", ok, 1);

      // timer paced only by ticks
      tick = 1'b0;
      en = 1'b0;
      adv(2);
      en = 1'b1;
      adv(30);
      chk("R8 no ticks no valid", ok, 0);
      tick = 1'b1;
      adv(LT - 1);
      chk("R8 not yet", ok, 0);
      adv(1);
      chk("R8 valid after ticks", ok, 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule